// File: doc/BRIEF.md
# Register-Bus Target Register Bank

This block is a target on a synchronous 16-bit register bus. The master shows an address with an address-valid line and then issues read or write strobes. The target answers in the same cycle with acknowledge, busy, error and read data. The bank holds a small set of 16-bit registers at a parameterised base address. Any chosen subset of them can be made read-only. One register drives a 16-bit attention vector back to the master. When that vector is nonzero, the target is asking to be serviced.

The target counts as addressed only in a cycle where address-valid is high and was also high in the cycle before. The first valid cycle only presents the address. Each access can be stretched by a fixed number of wait cycles, which are signalled on busy. While busy is high the master holds its strobe, and the access completes in the first cycle where busy is low. When the target is not addressed, or the address is outside its window, every response pin is held at zero. This lets several targets share one bus by OR-ing their responses. The bus interface is plain strobes with no valid/ready handshake, because busy already provides the back-pressure.

An init strobe is accepted only while the bus is idle. It carries a payload on the write-data bus. A nonzero payload sent to the base address returns every register to its reset value.

Top module: `rbank_slave`

## Requirements
- R1: The target is selected only in a cycle where `aval` is high and was also high in the previous cycle. A strobe in the first `aval` cycle produces no response and changes no register.
- R2: When the target is not selected, or the address lies outside `[BASE, BASE+NREG)`, the outputs `ack`, `busy` and `err` are 0 and `rdata` is 0.
- R3: `ack` is high in every cycle of a selected read or write to an in-range address, including the busy cycles.
- R4: Each in-range access holds `busy` high for exactly `WAIT` cycles (0 to 3) from its first strobe cycle. The cycle after those is the completing cycle. Out-of-range accesses never raise busy.
- R5: A read returns the addressed register (index = address − BASE) on `rdata` in its completing cycle. `rdata` is 0 in busy cycles.
- R6: A write to a writable register stores `wdata` at the end of the completing cycle. The new value is returned by later reads.
- R7: A write to a read-only register (bit i of `RO_MASK` set) completes with `ack` and `err` both high and leaves the register unchanged. `err` is 0 in busy cycles and on reads.
- R8: An `init` strobe with `aval` low, the previous `aval` low, `addr` == BASE and nonzero `wdata` restores all registers to their reset values. A zero payload, or any other address, has no effect.
- R9: `lam` always equals the register at index `LAM_IDX`. Any nonzero bit requests attention. `lam` changes only after a completing write or an init.
- R10: After reset, register i holds `RST_SEED | i`, except register `LAM_IDX`, which holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aval | input | 1 | Address valid |
| addr | input | 16 | Bus address |
| re | input | 1 | Read strobe |
| we | input | 1 | Write strobe |
| init | input | 1 | Init strobe, accepted only while the bus is idle |
| wdata | input | 16 | Write data or init payload |
| ack | output | 1 | Access acknowledged by this target |
| busy | output | 1 | Wait state; master holds its strobe |
| err | output | 1 | Write to a read-only register, on the completing cycle |
| rdata | output | 16 | Read data, valid in the completing read cycle |
| lam | output | 16 | Attention vector; nonzero requests service |

## Verification
The bench sweeps addresses from two below the window to two above it. At each address it writes several data patterns (all zeros, all ones, alternating bits, address-mixed) and reads every register back. This separates an off-by-one window decode, a swapped register index, a lost write and a read-only register that takes data. Every strobe is followed through its wait cycles, so the busy count and the timing of data and error within the access are checked cycle by cycle. Separate patterns strobe in the first address cycle and send init strobes with a zero payload, a wrong address and a correct address. These show whether the select delay and the init qualification are each respected.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int DW = 16;
  localparam int AW = 16;
  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;
endpackage

// File: rtl/rbank_decode.sv
module rbank_decode
  import rbank_pkg::*;
#(
  parameter addr_t BASE = 16'h0040,
  parameter int    NREG = 4,
  localparam int   IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  addr_t         addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [AW:0] off;

  always_comb begin
    off = {1'b0, addr} - {1'b0, BASE};
    hit = !off[AW] && (off < (AW+1)'(NREG));
    idx = off[IW-1:0];
  end
endmodule

// File: rtl/rbank_wait.sv
module rbank_wait #(
  parameter int WAIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic busy
);
  generate
    if (WAIT == 0) begin : g_nowait
      assign busy = 1'b0;
    end else begin : g_wait
      localparam int CW = $clog2(WAIT + 1);
      logic [CW-1:0] cnt;

      assign busy = active && (cnt != CW'(WAIT));

      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (active && busy) cnt <= cnt + 1'b1;
        else cnt <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/rbank_regs.sv
module rbank_regs
  import rbank_pkg::*;
#(
  parameter int          NREG     = 4,
  parameter logic [NREG-1:0] RO_MASK = 4'b1000,
  parameter word_t       RST_SEED = 16'h5A00,
  parameter int          LAM_IDX  = 2,
  localparam int         IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  word_t         wr_data,
  input  logic [IW-1:0] rd_idx,
  output word_t         rd_data,
  output word_t         lam
);
  word_t regs [NREG];

  function automatic word_t rst_val(input int i);
    return (i == LAM_IDX) ? '0 : (RST_SEED | word_t'(i));
  endfunction

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (RO_MASK[i]) begin : g_ro
        always_ff @(posedge clk) regs[i] <= rst_val(i);
      end else begin : g_rw
        always_ff @(posedge clk) begin
          if (rst || clr) regs[i] <= rst_val(i);
          else if (wr_en && (wr_idx == IW'(i))) regs[i] <= wr_data;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i)) rd_data = regs[i];
  end

  assign lam = regs[LAM_IDX];
endmodule

// File: rtl/rbank_slave.sv
module rbank_slave
  import rbank_pkg::*;
#(
  parameter addr_t           BASE     = 16'h0040,
  parameter int              NREG     = 4,
  parameter int              WAIT     = 2,
  parameter logic [NREG-1:0] RO_MASK  = 4'b1000,
  parameter word_t           RST_SEED = 16'h5A00,
  parameter int              LAM_IDX  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aval,
  input  logic [15:0] addr,
  input  logic        re,
  input  logic        we,
  input  logic        init,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic        busy,
  output logic        err,
  output logic [15:0] rdata,
  output logic [15:0] lam
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          sel_q;
  logic          sel;
  logic          hit;
  logic [IW-1:0] idx;
  logic          act;
  logic          wbusy;
  logic          done;
  logic          ro;
  logic          clr;
  word_t         rd;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else sel_q <= aval;
  end

  rbank_decode #(.BASE(BASE), .NREG(NREG)) u_dec (
    .addr(addr), .hit(hit), .idx(idx)
  );

  assign sel  = aval && sel_q;
  assign act  = sel && (re || we) && hit;

  rbank_wait #(.WAIT(WAIT)) u_wait (
    .clk(clk), .rst(rst), .active(act), .busy(wbusy)
  );

  assign done = act && !wbusy;

  always_comb begin
    ro = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i)) ro = RO_MASK[i];
  end

  assign clr = init && !aval && !sel_q && (addr == BASE) && (wdata != '0);

  rbank_regs #(
    .NREG(NREG), .RO_MASK(RO_MASK), .RST_SEED(RST_SEED), .LAM_IDX(LAM_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(done && we), .wr_idx(idx), .wr_data(wdata),
    .rd_idx(idx), .rd_data(rd), .lam(lam)
  );

  assign ack   = act;
  assign busy  = wbusy;
  assign err   = done && we && ro;
  assign rdata = (done && re) ? rd : '0;
endmodule

// File: rtl/rbank_checker.sv
module rbank_checker (
  input logic        clk,
  input logic        rst,
  input logic        aval,
  input logic        sel_q,
  input logic        re,
  input logic        we,
  input logic        init,
  input logic        ack,
  input logic        busy,
  input logic        err,
  input logic [15:0] rdata,
  input logic [15:0] lam
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!aval && !sel_q) |-> (!ack && !busy && !err && rdata == '0));

  p_ack_needs_select_r1: assert property (@(posedge clk) disable iff (rst)
    ack |-> (aval && sel_q && (re || we)));

  p_busy_with_ack_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> ack);

  p_err_on_done_write_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> (ack && !busy && we));

  p_no_data_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rdata == '0 && !err));

  p_lam_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(ack && we && !busy) && !$past(init)) |-> $stable(lam));
endmodule

bind rbank_slave rbank_checker u_chk (
  .clk(clk), .rst(rst), .aval(aval), .sel_q(sel_q), .re(re), .we(we),
  .init(init), .ack(ack), .busy(busy), .err(err), .rdata(rdata), .lam(lam)
);

// File: tb/test_rbank_slave.sv
`timescale 1ns/1ps
module test_rbank_slave;
  localparam logic [15:0] BASE = 16'h0040;
  localparam int NREG = 4;
  localparam int WAIT = 2;
  localparam logic [3:0] RO = 4'b1000;
  localparam logic [15:0] SEED = 16'h5A00;
  localparam int LAMI = 2;

  logic clk = 0, rst = 1, aval = 0, re = 0, we = 0, init = 0;
  logic [15:0] addr = 0, wdata = 0;
  logic ack, busy, err;
  logic [15:0] rdata, lam;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] model [NREG];

  always #2 clk = ~clk;

  rbank_slave #(.BASE(BASE), .NREG(NREG), .WAIT(WAIT), .RO_MASK(RO),
                .RST_SEED(SEED), .LAM_IDX(LAMI)) i_rbank_slave (
    .clk(clk), .rst(rst), .aval(aval), .addr(addr), .re(re), .we(we),
    .init(init), .wdata(wdata), .ack(ack), .busy(busy), .err(err),
    .rdata(rdata), .lam(lam));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk({ack, busy, err} == 3'b000 && rdata == 16'h0, req,
        {13'h0, ack, busy, err, rdata}, 32'h0);
  endtask

  function automatic logic [15:0] rv(input int i);
    return (i == LAMI) ? 16'h0 : (SEED | 16'(i));
  endfunction

  task automatic reset_model();
    for (int i = 0; i < NREG; i++) model[i] = rv(i);
  endtask

  task automatic do_access(input logic [15:0] a, input bit wr, input logic [15:0] d);
    bit hit;
    int ix;
    hit = (a >= BASE) && (a < BASE + NREG);
    ix = int'(a - BASE);
    @(negedge clk); aval = 1; addr = a;
    #1 chk_quiet("R1 first aval cycle");
    @(negedge clk); re = !wr; we = wr; wdata = d;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk(ack == hit, "R3 ack", ack, hit);
      chk(busy == (hit && k < WAIT), hit ? "R4 busy count" : "R2 busy out of range",
          busy, (hit && k < WAIT));
      if (!(hit && k < WAIT)) begin
        chk(err == (hit && wr && RO[ix & 3]), "R7 err", err, (hit && wr && RO[ix & 3]));
        chk(rdata == ((hit && !wr) ? model[ix] : 16'h0), hit ? "R5 read data" : "R2 rdata",
            rdata, (hit && !wr) ? model[ix] : 16'h0);
        if (hit && wr && !RO[ix & 3]) model[ix] = d;
        break;
      end
      chk(rdata == 16'h0 && !err, "R5 quiet during busy", {err, rdata}, 0);
      @(negedge clk);
    end
    @(negedge clk); aval = 0; re = 0; we = 0; wdata = 0;
    #1 chk_quiet("R2 after access");
    chk(lam == model[LAMI], "R9 lam mirror", lam, model[LAMI]);
  endtask

  task automatic read_all();
    for (int i = 0; i < NREG; i++) do_access(BASE + 16'(i), 0, 16'h0);
  endtask

  task automatic do_init(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); init = 1; addr = a; wdata = d;
    #1 chk_quiet("R8 init no response");
    @(negedge clk); init = 0; wdata = 0; addr = 0;
    if (a == BASE && d != 0) reset_model();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hAAAA; pats[3] = 16'h5555;
    reset_model();
    repeat (3) @(negedge clk);
    rst = 0;
    #1 chk_quiet("R2 reset state");
    chk(lam == 16'h0, "R10 lam reset", lam, 0);
    read_all();  // R10 reset values

    for (int p = 0; p < 4; p++)
      for (int a = int'(BASE) - 2; a < int'(BASE) + NREG + 2; a++) begin
        do_access(16'(a), 1, pats[p] ^ 16'(a * 16'h0101));  // R6 R7
        read_all();
      end

    // R1: strobe in first aval cycle is ignored
    @(negedge clk); aval = 1; addr = BASE; we = 1; wdata = 16'hDEAD;
    #1 chk_quiet("R1 early strobe");
    @(negedge clk); aval = 0; we = 0; wdata = 0;
    read_all();

    // R9: attention raised and cleared
    do_access(BASE + LAMI, 1, 16'h0001);
    chk(lam != 0, "R9 lam active", lam, 16'h0001);
    do_access(BASE + LAMI, 1, 16'h0000);

    do_access(BASE, 1, 16'h1234);
    do_access(BASE + LAMI, 1, 16'h8000);
    do_init(BASE, 16'h0000);      // R8 zero payload ignored
    read_all();
    do_init(BASE + 1, 16'h00FF);  // R8 wrong address ignored
    read_all();
    do_init(BASE, 16'h0001);      // R8 restores reset values
    read_all();
    chk(lam == 16'h0, "R8 lam cleared by init", lam, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule